// File: doc/BRIEF.md
# Panel Raster Timing Generator

This block drives the control side of a parallel RGB panel. It produces horizontal sync, vertical sync, a data-enable strobe and zero-based pixel coordinates. Timing comes from programmable sync widths, back porches, front porches and active sizes. A source clock is turned into a pixel-clock enable, either by a programmable divider or by passing it through at 1:1. A frame interrupt can be raised at a selectable point in the frame.

Software programs the block through a simple write port. Every timing and size field is written as its count minus one. The display enable and the divider settings are double-buffered. While the raster is running, a new value waits for the next frame start. While the raster is stopped, it takes effect on the following clock. The frame interrupt has its own enables, a trigger select and a pending flag that software clears by writing a one. The block has no streaming interface: every pin is plain control or status, and nothing can back-pressure it.

Register addresses on `wr_addr`:

- 0 is control.
- 1 is vertical timing.
- 2 is horizontal timing.
- 3 is active size.
- 4 is polarity.
- 5 is interrupt configuration.
- 6 is interrupt status.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, `hsync_o`, `vsync_o`, `de_o`, `pix_tick_o` and `irq_o` are 0, and both coordinates are 0.
- R2: Horizontal timing (address 2) holds sync[7:0], back porch[15:8] and front porch[23:16], each as its count minus one. Active pixels (address 3, bits [10:0]) are also written minus one. A line holds the sum of the four counts in pixel ticks, in this order: sync, back porch, active, front porch. Logical hsync is high during the sync part of the line.
- R3: Vertical timing (address 1) uses the same field layout, counted in lines. Active lines (address 3, bits [26:16]) are written minus one. A frame starts with its sync lines, and logical vsync is high during those lines.
- R4: `de_o` is high only on pixels that lie in the active part of both the line and the frame. `pix_x_o` and `pix_y_o` give the 0-based position inside the active area, and both are 0 whenever data enable is low.
- R5: Control bit 1 selects the divided clock. When it is 1, `pix_tick_o` pulses once every (control[15:8] + 1) cycles. When it is 0, `pix_tick_o` is high on every cycle while the raster runs.
- R6: Control bit 0 is the display enable. While the raster runs, writes to control bits 0, 1 and [15:8] take effect only at the next frame start. While the raster is stopped, they take effect on the next cycle, and the counters start at the first sync line.
- R7: Polarity bits 0, 1 and 2 (address 4) invert hsync, vsync and data enable at the pins. Each bit acts independently, and each takes effect at once.
- R8: Interrupt configuration bits [5:4] select the event that sets the pending flag. 0 is a frame start, 1 is the start of the first active line, 2 is the start of the first front-porch line, and 3 is never.
- R9: `irq_o` equals the pending flag ANDed with the global enable (configuration bit 0) and the frame enable (configuration bit 1).
- R10: Writing 1 to bit 0 of address 6 clears the pending flag, and writing 0 has no effect. An event in the same cycle as the clear wins, so the flag stays set.
- R11: While running, the frame lasts (sum of horizontal counts) × (sum of vertical counts) pixel ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data enable after polarity |
| pix_x_o | output | 11 | Active column, 0-based |
| pix_y_o | output | 11 | Active row, 0-based |
| pix_tick_o | output | 1 | Pixel-clock enable |
| irq_o | output | 1 | Frame interrupt |

## Verification
The bench writes a divider change in the middle of a frame. A design that applied the change at once would stretch the pixel ticks too early, and the bench counts those ticks. It clears the pending flag both with a zero write and with a one write, and it switches the interrupt enables after an event has been latched. A design that cleared on any write, or that gated the flag itself instead of the output, would miss or lose an interrupt. Each trigger select, including the never setting, runs across full frames. All polarity bits are flipped, and the enable is dropped mid-frame to confirm that the raster stops only at the frame boundary.

// File: rtl/raster_pkg.sv
`timescale 1ns/1ps
package raster_pkg;
  parameter int unsigned PORCH_W = 8;
  parameter int unsigned SIZE_W  = 11;
  parameter int unsigned DIV_W   = 8;
  // position counters must hold three porch fields plus the active size
  localparam int unsigned CNT_W = $clog2(3 * (2 ** PORCH_W) + (2 ** SIZE_W) + 1);

  typedef struct packed {
    logic [PORCH_W-1:0] sync_m1;
    logic [PORCH_W-1:0] back_m1;
    logic [PORCH_W-1:0] front_m1;
    logic [SIZE_W-1:0]  act_m1;
  } axis_cfg_t;

  typedef enum logic [1:0] {
    TRIG_FRAME  = 2'd0,
    TRIG_ACTIVE = 2'd1,
    TRIG_FRONT  = 2'd2,
    TRIG_NONE   = 2'd3
  } irq_trig_e;
endpackage

// File: rtl/pix_divider.sv
`timescale 1ns/1ps
module pix_divider import raster_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             div_sel_i,
  input  logic [DIV_W-1:0] ratio_m1_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (!div_sel_i || (cnt_q == ratio_m1_i));

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + DIV_W'(1);
  end

  // R5: with a ratio above one and steady settings, ticks never come back to back
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_sel_i && (ratio_m1_i != '0)) |=>
      (!tick_o || !run_i || !$stable(ratio_m1_i) || !$stable(div_sel_i)));
endmodule

// File: rtl/raster_axis.sv
`timescale 1ns/1ps
module raster_axis import raster_pkg::*; (
  input  logic [CNT_W-1:0]  pos_i,
  input  axis_cfg_t         cfg_i,
  output logic [CNT_W-1:0]  last_o,
  output logic [CNT_W-1:0]  act_begin_o,
  output logic [CNT_W-1:0]  fp_begin_o,
  output logic              in_sync_o,
  output logic              in_act_o,
  output logic [SIZE_W-1:0] coord_o
);
  logic [CNT_W-1:0] sync_len;
  logic [CNT_W-1:0] total;

  always_comb begin
    sync_len    = CNT_W'(cfg_i.sync_m1) + CNT_W'(1);
    act_begin_o = sync_len + CNT_W'(cfg_i.back_m1) + CNT_W'(1);
    fp_begin_o  = act_begin_o + CNT_W'(cfg_i.act_m1) + CNT_W'(1);
    total       = fp_begin_o + CNT_W'(cfg_i.front_m1) + CNT_W'(1);
    last_o      = total - CNT_W'(1);
    in_sync_o   = pos_i < sync_len;
    in_act_o    = (pos_i >= act_begin_o) && (pos_i < fp_begin_o);
    coord_o     = in_act_o ? SIZE_W'(pos_i - act_begin_o) : '0;
  end
endmodule

// File: rtl/raster_core.sv
`timescale 1ns/1ps
module raster_core import raster_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              tick_i,
  input  axis_cfg_t         hcfg_i,
  input  axis_cfg_t         vcfg_i,
  output logic              hs_o,
  output logic              vs_o,
  output logic              de_o,
  output logic [SIZE_W-1:0] x_o,
  output logic [SIZE_W-1:0] y_o,
  output logic              line_end_o,
  output logic [CNT_W-1:0]  v_next_o,
  output logic [CNT_W-1:0]  v_act_begin_o,
  output logic [CNT_W-1:0]  v_fp_begin_o
);
  logic [CNT_W-1:0]  h_q, v_q, h_last, v_last;
  logic [CNT_W-1:0]  unused_h_act, unused_h_fp;
  logic              h_sync, h_act, v_sync, v_act;
  logic [SIZE_W-1:0] hx, vy;

  raster_axis u_h (
    .pos_i(h_q), .cfg_i(hcfg_i), .last_o(h_last),
    .act_begin_o(unused_h_act), .fp_begin_o(unused_h_fp),
    .in_sync_o(h_sync), .in_act_o(h_act), .coord_o(hx)
  );

  raster_axis u_v (
    .pos_i(v_q), .cfg_i(vcfg_i), .last_o(v_last),
    .act_begin_o(v_act_begin_o), .fp_begin_o(v_fp_begin_o),
    .in_sync_o(v_sync), .in_act_o(v_act), .coord_o(vy)
  );

  assign v_next_o   = (v_q >= v_last) ? '0 : v_q + CNT_W'(1);
  assign line_end_o = run_i && tick_i && (h_q >= h_last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      h_q <= '0;
      v_q <= '0;
    end else if (tick_i) begin
      if (h_q >= h_last) begin
        h_q <= '0;
        v_q <= v_next_o;
      end else begin
        h_q <= h_q + CNT_W'(1);
      end
    end
  end

  assign hs_o = run_i && h_sync;
  assign vs_o = run_i && v_sync;
  assign de_o = run_i && h_act && v_act;
  assign x_o  = de_o ? hx : '0;
  assign y_o  = de_o ? vy : '0;

  // R2: a line end always returns the column to zero
  a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    line_end_o |=> (h_q == '0));
  // R4: data enable never overlaps either sync region
  a_r4_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> (!hs_o && !vs_o));
endmodule

// File: rtl/irq_unit.sv
`timescale 1ns/1ps
module irq_unit import raster_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start_i,
  input  logic             line_end_i,
  input  logic [CNT_W-1:0] v_next_i,
  input  logic [CNT_W-1:0] v_act_begin_i,
  input  logic [CNT_W-1:0] v_fp_begin_i,
  input  irq_trig_e        trig_i,
  input  logic             glob_en_i,
  input  logic             frame_en_i,
  input  logic             clr_i,
  output logic             irq_o
);
  logic evt, pend_q;

  always_comb begin
    unique case (trig_i)
      TRIG_FRAME:  evt = frame_start_i;
      TRIG_ACTIVE: evt = line_end_i && (v_next_i == v_act_begin_i);
      TRIG_FRONT:  evt = line_end_i && (v_next_i == v_fp_begin_i);
      default:     evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (evt)   pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign irq_o = pend_q && glob_en_i && frame_en_i;

  // R8: a selected event always leaves the flag set
  a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend_q);
  // R10: a clear with no competing event empties the flag
  a_r10_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt) |=> !pend_q);
endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen import raster_pkg::*; #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [SIZE_W-1:0] pix_x_o,
  output logic [SIZE_W-1:0] pix_y_o,
  output logic              pix_tick_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_VTIM = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_HTIM = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_SIZE = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_ICFG = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_ISTA = ADDR_W'(6);
  localparam int unsigned BP_LSB  = 8;
  localparam int unsigned FP_LSB  = 16;
  localparam int unsigned DIV_LSB = 8;
  localparam int unsigned VSZ_LSB = 16;

  logic             p_en, p_dsel, a_en, a_dsel;
  logic [DIV_W-1:0] p_ratio, a_ratio;
  axis_cfg_t        hcfg, vcfg;
  logic [2:0]       pol;
  logic             glob_en, frame_en;
  irq_trig_e        trig;
  logic             tick, hs_l, vs_l, de_l, line_end;
  logic [CNT_W-1:0] v_next, v_act_begin, v_fp_begin;
  logic             frame_wrap, frame_start, clr;
  logic             unused_bits;

  assign unused_bits = ^wr_data[DATA_W-1:VSZ_LSB+SIZE_W];

  // register write port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_en <= 1'b0; p_dsel <= 1'b0; p_ratio <= '0;
      hcfg <= '0; vcfg <= '0; pol <= '0;
      glob_en <= 1'b0; frame_en <= 1'b0; trig <= TRIG_FRAME;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_CTRL: begin
          p_en    <= wr_data[0];
          p_dsel  <= wr_data[1];
          p_ratio <= wr_data[DIV_LSB +: DIV_W];
        end
        A_VTIM: begin
          vcfg.sync_m1  <= wr_data[0 +: PORCH_W];
          vcfg.back_m1  <= wr_data[BP_LSB +: PORCH_W];
          vcfg.front_m1 <= wr_data[FP_LSB +: PORCH_W];
        end
        A_HTIM: begin
          hcfg.sync_m1  <= wr_data[0 +: PORCH_W];
          hcfg.back_m1  <= wr_data[BP_LSB +: PORCH_W];
          hcfg.front_m1 <= wr_data[FP_LSB +: PORCH_W];
        end
        A_SIZE: begin
          hcfg.act_m1 <= wr_data[0 +: SIZE_W];
          vcfg.act_m1 <= wr_data[VSZ_LSB +: SIZE_W];
        end
        A_POL:  pol <= wr_data[2:0];
        A_ICFG: begin
          glob_en  <= wr_data[0];
          frame_en <= wr_data[1];
          trig     <= irq_trig_e'(wr_data[5:4]);
        end
        default: ;
      endcase
    end
  end

  assign clr         = wr_en && (wr_addr == A_ISTA) && wr_data[0];
  assign frame_wrap  = line_end && (v_next == '0);
  assign frame_start = frame_wrap || (!a_en && p_en);

  // frame-synchronous shadow of enable and divider
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_en <= 1'b0; a_dsel <= 1'b0; a_ratio <= '0;
    end else if (!a_en || frame_wrap) begin
      a_en <= p_en; a_dsel <= p_dsel; a_ratio <= p_ratio;
    end
  end

  pix_divider u_div (
    .clk(clk), .rst_n(rst_n), .run_i(a_en), .div_sel_i(a_dsel),
    .ratio_m1_i(a_ratio), .tick_o(tick)
  );

  raster_core u_core (
    .clk(clk), .rst_n(rst_n), .run_i(a_en), .tick_i(tick),
    .hcfg_i(hcfg), .vcfg_i(vcfg),
    .hs_o(hs_l), .vs_o(vs_l), .de_o(de_l), .x_o(pix_x_o), .y_o(pix_y_o),
    .line_end_o(line_end), .v_next_o(v_next),
    .v_act_begin_o(v_act_begin), .v_fp_begin_o(v_fp_begin)
  );

  irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start),
    .line_end_i(line_end), .v_next_i(v_next),
    .v_act_begin_i(v_act_begin), .v_fp_begin_i(v_fp_begin),
    .trig_i(trig), .glob_en_i(glob_en), .frame_en_i(frame_en),
    .clr_i(clr), .irq_o(irq_o)
  );

  assign hsync_o    = hs_l ^ pol[0];
  assign vsync_o    = vs_l ^ pol[1];
  assign de_o       = de_l ^ pol[2];
  assign pix_tick_o = tick;

  // R6: mid-frame, the live enable and divider never move
  a_r6_hold_midframe: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && !frame_wrap) |=> (a_en && $stable(a_ratio) && $stable(a_dsel)));
endmodule

// File: tb/sim_raster_timing_gen.sv
`timescale 1ns/1ps
module sim_raster_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hsync_o, vsync_o, de_o, pix_tick_o, irq_o;
  logic [10:0] pix_x_o, pix_y_o;

  int checks = 0;
  int failures = 0;
  bit cmp_on = 0;

  raster_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_x_o(pix_x_o),
    .pix_y_o(pix_y_o), .pix_tick_o(pix_tick_o), .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  m_h, m_v, m_dc, m_am1, m_pm1, m_sel;
  int  hsl, hbl, hfl, hal, vsl, vbl, vfl, val;
  bit  m_aen, m_adsel, m_pen, m_pdsel, m_g, m_f, m_pend;
  bit [2:0] m_pol;

  function automatic bit m_tick();
    return m_aen && (!m_adsel || m_dc == m_am1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_h = 0; m_v = 0; m_dc = 0; m_am1 = 0; m_pm1 = 0; m_sel = 0;
      hsl = 1; hbl = 1; hfl = 1; hal = 1; vsl = 1; vbl = 1; vfl = 1; val = 1;
      m_aen = 0; m_adsel = 0; m_pen = 0; m_pdsel = 0; m_g = 0; m_f = 0; m_pend = 0;
      m_pol = 0;
    end else begin
      int htot, vtot, vn;
      bit tk, le, wrap, ev;
      htot = hsl + hbl + hal + hfl;
      vtot = vsl + vbl + val + vfl;
      tk = m_tick();
      le = tk && (m_h >= htot - 1);
      vn = (m_v >= vtot - 1) ? 0 : m_v + 1;
      wrap = le && (vn == 0);
      case (m_sel)
        0: ev = wrap || (!m_aen && m_pen);
        1: ev = le && (vn == vsl + vbl);
        2: ev = le && (vn == vsl + vbl + val);
        default: ev = 0;
      endcase
      if (ev) m_pend = 1;
      else if (wr_en && wr_addr == 6 && wr_data[0]) m_pend = 0;
      if (!m_aen) begin m_h = 0; m_v = 0; m_dc = 0; end
      else if (tk) begin
        m_dc = 0;
        if (m_h >= htot - 1) begin m_h = 0; m_v = vn; end
        else m_h = m_h + 1;
      end else m_dc = m_dc + 1;
      if (!m_aen || wrap) begin m_aen = m_pen; m_adsel = m_pdsel; m_am1 = m_pm1; end
      if (wr_en) begin
        case (wr_addr)
          0: begin m_pen = wr_data[0]; m_pdsel = wr_data[1]; m_pm1 = int'(wr_data[15:8]); end
          1: begin vsl = wr_data[7:0] + 1; vbl = wr_data[15:8] + 1; vfl = wr_data[23:16] + 1; end
          2: begin hsl = wr_data[7:0] + 1; hbl = wr_data[15:8] + 1; hfl = wr_data[23:16] + 1; end
          3: begin hal = wr_data[10:0] + 1; val = wr_data[26:16] + 1; end
          4: m_pol = wr_data[2:0];
          5: begin m_g = wr_data[0]; m_f = wr_data[1]; m_sel = int'(wr_data[5:4]); end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      bit hl, vl, dl;
      int ex, ey;
      hl = m_aen && (m_h < hsl);
      vl = m_aen && (m_v < vsl);
      dl = m_aen && (m_h >= hsl + hbl) && (m_h < hsl + hbl + hal)
                 && (m_v >= vsl + vbl) && (m_v < vsl + vbl + val);
      ex = dl ? m_h - hsl - hbl : 0;
      ey = dl ? m_v - vsl - vbl : 0;
      check("R2 R7 hsync", int'(hsync_o), int'(hl ^ m_pol[0]));
      check("R3 R7 vsync", int'(vsync_o), int'(vl ^ m_pol[1]));
      check("R4 R7 de", int'(de_o), int'(dl ^ m_pol[2]));
      check("R4 x", int'(pix_x_o), ex);
      check("R4 y", int'(pix_y_o), ey);
      check("R5 R6 tick", int'(pix_tick_o), int'(m_tick()));
      check("R8 R9 irq", int'(irq_o), int'(m_pend && m_g && m_f));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pix_tick_o) c++;
    end
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 600; i++) begin
      if (irq_o) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 hsync", int'(hsync_o), 0);
    check("R1 vsync", int'(vsync_o), 0);
    check("R1 de", int'(de_o), 0);
    check("R1 tick", int'(pix_tick_o), 0);
    check("R1 irq", int'(irq_o), 0);
    check("R1 xy", int'(pix_x_o) + int'(pix_y_o), 0);
    cmp_on = 1;

    // horizontal: sync 2, back 1, front 2; vertical 1/1/1; active 4 x 3
    wr(2, 32'h0001_0001);
    wr(1, 32'h0000_0000);
    wr(3, (2 << 16) | 3);
    wr(5, 32'h3);
    wr(0, 32'h1);
    // R6 stopped raster starts at once
    count_ticks(2, c);
    check("R6 idle start", c, 2);
    // R11 one frame is 9 x 6 = 54 ticks at 1:1
    count_ticks(54, c);
    check("R11 frame ticks", c, 54);
    repeat (60) @(negedge clk);

    // R10 clear behaviour, then deferred divider change
    wr(6, 0);
    wait_irq();
    check("R8 frame start irq", int'(irq_o), 1);
    wr(6, 0);
    check("R10 write zero keeps", int'(irq_o), 1);
    wr(6, 1);
    check("R10 write one clears", int'(irq_o), 0);
    wr(0, 32'h1 | 32'h2 | (2 << 8));
    count_ticks(20, c);
    check("R6 divider deferred", c, 20);
    wait_irq();
    wr(6, 1);
    count_ticks(30, c);
    check("R5 divide by three", c, 10);

    // R7 inverted pins
    wr(4, 7);
    repeat (200) @(negedge clk);
    wr(4, 0);

    // R8 first active line trigger
    wr(5, 32'h3 | (1 << 4));
    wr(6, 1);
    wait_irq();
    check("R8 active trigger", int'(irq_o), 1);
    wr(6, 1);
    // R8 front porch trigger
    wr(5, 32'h3 | (2 << 4));
    wait_irq();
    check("R8 front trigger", int'(irq_o), 1);
    wr(6, 1);
    // R8 never
    wr(5, 32'h3 | (3 << 4));
    c = 0;
    for (int i = 0; i < 340; i++) begin
      @(negedge clk);
      if (irq_o) c++;
    end
    check("R8 never trigger", c, 0);

    // R9 global enable gates the pin, not the flag
    wr(5, 32'h2);
    c = 0;
    for (int i = 0; i < 340; i++) begin
      @(negedge clk);
      if (irq_o) c++;
    end
    check("R9 gated off", c, 0);
    wr(5, 32'h3);
    check("R9 latched flag shows", int'(irq_o), 1);

    // R6 disable waits for frame end
    wr(0, 0);
    count_ticks(6, c);
    check("R6 still running", int'(c > 0), 1);
    repeat (200) @(negedge clk);
    count_ticks(10, c);
    check("R6 stopped", c, 0);
    check("R6 de low when stopped", int'(de_o), 0);

    cmp_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule